// File: doc/BRIEF.md
# Series Compensator Fault Mode Supervisor

This block chooses the operating mode of a series-connected voltage compensator. On each sample strobe it takes the rotating-frame direct and quadrature components of the line current and the magnitude of the load-side voltage. It then decides whether the compensator should keep correcting supply voltage disturbances or switch to limiting a fault current downstream of it. The trip test runs on every sample. It compares the squared instantaneous current magnitude with a squared threshold, so the test needs neither a square root nor a full line cycle of data.

Once the block trips, it holds the limiter on and raises a command that makes the injected voltage lead the line current by a quarter period, so that the compensator acts as a pure inductance. The limiter is released only after the load voltage has stayed at or above a programmable restoration level for a qualification window. That window is counted in sample strobes. It has one length for symmetrical faults and a longer one for unsymmetrical faults. A fresh trip during the window, or a dip in the load voltage, sends the block back to limiting, and the window starts again from the beginning. The return to normal operation is therefore low-pass filtered. A one-cycle pulse marks every change of mode so that downstream regulators can clear their integrators.

Top module: `sc_fault_supervisor`

## Requirements
- R1: The state changes only on a clock edge where `smp_vld` is high. On other edges the mode is held and `mode_chg` stays low.
- R2: On each strobe the block forms m = d² + q² from the signed current components as a 33-bit unsigned value. A trip is m strictly greater than `trip_sq`. In compensation mode a trip moves the block to limiting mode at that strobe's edge. Mode codes on `mode`: 2'b00 compensate, 2'b01 limit, 2'b10 qualify.
- R3: `lim_on` is high in limit and qualify modes and low in compensate mode. This flag commands the 90-degree-leading, purely inductive injection. `recov_busy` is high only in qualify mode.
- R4: In limit mode, a strobe with no trip and `v_load` >= `v_restore` (unsigned) enters qualify mode. A lower `v_load`, or a trip, keeps the block in limit mode.
- R5: In qualify mode the block returns to compensate mode on the W-th further consecutive strobe that has no trip and a restored voltage. W is the latched window, and a latched value of 0 counts as 1. Limit mode never goes straight to compensate mode.
- R6: W is latched on the strobe that enters qualify mode. It is `win_sym` when `fault_sym` is high at that strobe and `win_asym` otherwise. Later changes to these inputs do not affect a window already running.
- R7: A trip during qualify mode returns the block to limit mode. The next entry into qualify mode loads a full new window.
- R8: A strobe in qualify mode with `v_load` below `v_restore` returns the block to limit mode.
- R9: `mode_chg` is high for exactly the first cycle in which a new mode appears on `mode`, and low in every other cycle.
- R10: While the synchronous, active-high `rst` is sampled high, the block goes to compensate mode with `lim_on`, `recov_busy` and `mode_chg` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| cur_d | input | 16 | Signed direct-axis current sample |
| cur_q | input | 16 | Signed quadrature-axis current sample |
| v_load | input | 16 | Unsigned load-voltage magnitude |
| trip_sq | input | 33 | Squared current trip threshold |
| v_restore | input | 16 | Load-voltage restoration level |
| fault_sym | input | 1 | High when the present fault is symmetrical |
| win_sym | input | 16 | Qualification window for symmetrical faults, in strobes |
| win_asym | input | 16 | Qualification window for unsymmetrical faults, in strobes |
| mode | output | 2 | Current operating mode |
| lim_on | output | 1 | Limiter active; inductive, 90-degree-leading injection |
| recov_busy | output | 1 | Recovery qualification in progress |
| mode_chg | output | 1 | One-cycle pulse on each mode change |

## Verification
The bench keeps the default 16-bit data widths, so the trip comparator can be pushed to its extremes. These include a magnitude exactly equal to the threshold and the full-scale negative corner, where m reaches 2^31. The window inputs are driven with small counts: 3 strobes for symmetrical faults, 5 for unsymmetrical faults, and a run with 0. With these counts every window expiry, every restart after a fresh trip and every voltage dip inside a window can be reached within a few dozen strobes. Changing `fault_sym` part-way through a window shows that the latched length is the one in force.

// File: rtl/sc_fault_pkg.sv
package sc_fault_pkg;

    typedef enum logic [1:0] {
        MODE_COMP  = 2'b00,
        MODE_LIMIT = 2'b01,
        MODE_QUAL  = 2'b10
    } sc_mode_e;

endpackage

// File: rtl/sc_mag_detect.sv
module sc_mag_detect #(
    parameter int IW = 16,
    localparam int PW = 2 * IW,
    localparam int MW = PW + 1
) (
    input  logic signed [IW-1:0] cur_d,
    input  logic signed [IW-1:0] cur_q,
    input  logic        [MW-1:0] trip_sq,
    output logic        [MW-1:0] mag_sq,
    output logic                 over
);

    logic signed [PW-1:0] d_ext;
    logic signed [PW-1:0] q_ext;
    logic signed [PW-1:0] d_prod;
    logic signed [PW-1:0] q_prod;

    always_comb begin
        d_ext  = {{IW{cur_d[IW-1]}}, cur_d};
        q_ext  = {{IW{cur_q[IW-1]}}, cur_q};
        d_prod = d_ext * d_ext;
        q_prod = q_ext * q_ext;
        mag_sq = {1'b0, d_prod} + {1'b0, q_prod};
        over   = (mag_sq > trip_sq);
    end

endmodule

// File: rtl/sc_qual_timer.sv
module sc_qual_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] win,
    input  logic          dec,
    input  logic          clear,
    output logic          expire
);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = (win == '0) ? CW'(1) : win;
        end else if (dec && tmr_q.run) begin
            if (tmr_q.cnt == CW'(1)) begin
                tmr_d.run = 1'b0;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign expire = tmr_q.run && (tmr_q.cnt == CW'(1));

    AST_RUN_CNT_NZ: assert property (@(posedge clk) disable iff (rst)
        tmr_q.run |-> (tmr_q.cnt != '0)); // R5
    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (tmr_q.run && tmr_q.cnt != '0)); // R7

endmodule

// File: rtl/sc_mode_fsm.sv
module sc_mode_fsm
    import sc_fault_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic          over,
    input  logic          restored,
    input  logic          expire,
    input  logic          fault_sym,
    input  logic [CW-1:0] win_sym,
    input  logic [CW-1:0] win_asym,
    output sc_mode_e      mode,
    output logic          chg_pulse,
    output logic          tm_load,
    output logic [CW-1:0] tm_win,
    output logic          tm_dec,
    output logic          tm_clear
);

    typedef struct packed {
        sc_mode_e st;
        logic     pulse;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.pulse = 1'b0;
        tm_load     = 1'b0;
        tm_dec      = 1'b0;
        tm_clear    = 1'b0;
        tm_win      = fault_sym ? win_sym : win_asym;
        if (smp_vld) begin
            unique case (fsm_q.st)
                MODE_COMP: begin
                    if (over) fsm_d.st = MODE_LIMIT;
                end
                MODE_LIMIT: begin
                    if (!over && restored) begin
                        fsm_d.st = MODE_QUAL;
                        tm_load  = 1'b1;
                    end
                end
                MODE_QUAL: begin
                    if (over || !restored) begin
                        fsm_d.st = MODE_LIMIT;
                        tm_clear = 1'b1;
                    end else begin
                        tm_dec = 1'b1;
                        if (expire) fsm_d.st = MODE_COMP;
                    end
                end
                default: begin
                    fsm_d.st = MODE_COMP;
                    tm_clear = 1'b1;
                end
            endcase
        end
        fsm_d.pulse = (fsm_d.st != fsm_q.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st    <= MODE_COMP;
            fsm_q.pulse <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign mode      = fsm_q.st;
    assign chg_pulse = fsm_q.pulse;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(fsm_q.st)); // R1
    AST_TRIP_ENTER: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == MODE_COMP && smp_vld && over) |=> (fsm_q.st == MODE_LIMIT)); // R2
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == MODE_LIMIT) |=> (fsm_q.st != MODE_COMP)); // R5
    AST_REFAULT: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == MODE_QUAL && smp_vld && over) |=> (fsm_q.st == MODE_LIMIT)); // R7
    AST_DIP_BACK: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == MODE_QUAL && smp_vld && !restored) |=> (fsm_q.st == MODE_LIMIT)); // R8
    AST_PULSE_ON_CHG: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st != $past(fsm_q.st)) |-> fsm_q.pulse); // R9
    AST_PULSE_ONLY_CHG: assert property (@(posedge clk) disable iff (rst)
        fsm_q.pulse |-> (fsm_q.st != $past(fsm_q.st))); // R9
    AST_RESET_COMP: assert property (@(posedge clk)
        rst |=> (fsm_q.st == MODE_COMP && !fsm_q.pulse)); // R10

endmodule

// File: rtl/sc_fault_supervisor.sv
module sc_fault_supervisor
    import sc_fault_pkg::*;
#(
    parameter int IW = 16,
    parameter int VW = 16,
    parameter int CW = 16,
    localparam int MW = 2 * IW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [IW-1:0] cur_d,
    input  logic signed [IW-1:0] cur_q,
    input  logic        [VW-1:0] v_load,
    input  logic        [MW-1:0] trip_sq,
    input  logic        [VW-1:0] v_restore,
    input  logic                 fault_sym,
    input  logic        [CW-1:0] win_sym,
    input  logic        [CW-1:0] win_asym,
    output logic        [1:0]    mode,
    output logic                 lim_on,
    output logic                 recov_busy,
    output logic                 mode_chg
);

    logic [MW-1:0] mag_sq;
    logic          over;
    logic          restored;
    logic          expire;
    logic          tm_load;
    logic          tm_dec;
    logic          tm_clear;
    logic [CW-1:0] tm_win;
    sc_mode_e      st;

    sc_mag_detect #(.IW(IW)) u_mag (
        .cur_d   (cur_d),
        .cur_q   (cur_q),
        .trip_sq (trip_sq),
        .mag_sq  (mag_sq),
        .over    (over)
    );

    assign restored = (v_load >= v_restore);

    sc_mode_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .over      (over),
        .restored  (restored),
        .expire    (expire),
        .fault_sym (fault_sym),
        .win_sym   (win_sym),
        .win_asym  (win_asym),
        .mode      (st),
        .chg_pulse (mode_chg),
        .tm_load   (tm_load),
        .tm_win    (tm_win),
        .tm_dec    (tm_dec),
        .tm_clear  (tm_clear)
    );

    sc_qual_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tm_load),
        .win    (tm_win),
        .dec    (tm_dec),
        .clear  (tm_clear),
        .expire (expire)
    );

    assign mode       = st;
    assign lim_on     = (st != MODE_COMP);
    assign recov_busy = (st == MODE_QUAL);

    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (mag_sq <= (MW'(1) << (2 * IW - 1)))); // R2
    AST_BUSY_IMPLIES_LIM: assert property (@(posedge clk) disable iff (rst)
        recov_busy |-> lim_on); // R3
    AST_TIMER_QUAL: assert property (@(posedge clk) disable iff (rst)
        expire |-> recov_busy); // R5

endmodule

// File: tb/tb_sc_fault_supervisor.sv
module tb_sc_fault_supervisor;

    localparam int IW = 16;
    localparam int VW = 16;
    localparam int CW = 16;
    localparam int MW = 2 * IW + 1;
    localparam logic [MW-1:0] THR = MW'(1000000);

    typedef struct {
        logic [1:0] mode;
        logic       pulse;
        string      tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_vld = 1'b0;
    logic signed [IW-1:0] cur_d = '0;
    logic signed [IW-1:0] cur_q = '0;
    logic        [VW-1:0] v_load = '0;
    logic        [MW-1:0] trip_sq = THR;
    logic        [VW-1:0] v_restore = VW'(900);
    logic                 fault_sym = 1'b1;
    logic        [CW-1:0] win_sym = CW'(3);
    logic        [CW-1:0] win_asym = CW'(5);
    logic        [1:0]    mode;
    logic                 lim_on;
    logic                 recov_busy;
    logic                 mode_chg;

    int         n_cmp = 0;
    int         n_bad = 0;
    exp_t       sb[$];
    logic [1:0] drv_last = 2'b00;
    logic [1:0] mon_last = 2'b00;

    always #4 clk = ~clk;

    sc_fault_supervisor #(.IW(IW), .VW(VW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .cur_d(cur_d), .cur_q(cur_q),
        .v_load(v_load), .trip_sq(trip_sq), .v_restore(v_restore),
        .fault_sym(fault_sym), .win_sym(win_sym), .win_asym(win_asym),
        .mode(mode), .lim_on(lim_on), .recov_busy(recov_busy), .mode_chg(mode_chg)
    );

    task automatic cmp_out(input logic [1:0] em, input logic ep, input string tag);
        n_cmp++;
        if (mode !== em || lim_on !== (em != 2'b00) || recov_busy !== (em == 2'b10)
            || mode_chg !== ep) begin
            n_bad++;
            $display("FAIL %s: mode=%0d lim=%0b busy=%0b chg=%0b expected mode=%0d lim=%0b busy=%0b chg=%0b",
                     tag, mode, lim_on, recov_busy, mode_chg,
                     em, (em != 2'b00), (em == 2'b10), ep);
        end
    endtask

    // driver: one strobe, expected result pushed to the scoreboard
    task automatic smp(input int d, input int q, input int v,
                       input logic [1:0] em, input string tag);
        exp_t e;
        @(negedge clk);
        cur_d   = IW'(d);
        cur_q   = IW'(q);
        v_load  = VW'(v);
        smp_vld = 1'b1;
        e.mode  = em;
        e.pulse = (em != drv_last);
        e.tag   = tag;
        drv_last = em;
        sb.push_back(e);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        cmp_out(2'b00, 1'b0, "R10 reset state");
        drv_last = 2'b00;
        rst = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops scoreboard on strobe edges, checks hold otherwise
    initial begin
        forever begin
            logic was_s;
            logic was_r;
            @(posedge clk);
            was_s = smp_vld;
            was_r = rst;
            @(negedge clk);
            if (was_r) begin
                mon_last = 2'b00;
            end else if (was_s) begin
                if (sb.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R1: strobe with empty scoreboard, mode=%0d expected none", mode);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    cmp_out(e.mode, e.pulse, e.tag);
                    mon_last = e.mode;
                end
            end else begin
                cmp_out(mon_last, 1'b0, "R1 R9 hold between strobes");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2: below and exactly at threshold, then one above
        smp(100, 100, 1000, 2'b00, "R2 small current");
        smp(1000, 0, 1000, 2'b00, "R2 equal threshold no trip");
        smp(1000, 1, 500, 2'b01, "R2 R3 trip to limit");
        // R4
        smp(0, 0, 800, 2'b01, "R4 low voltage stays limit");
        smp(600, 900, 1000, 2'b01, "R4 trip in limit stays limit");
        fault_sym = 1'b1;
        smp(0, 0, 900, 2'b10, "R4 R3 enter qualify at level");
        fault_sym = 1'b0;
        // R5/R6: symmetrical window 3 latched despite flag change
        smp(0, 0, 950, 2'b10, "R6 qualify 1");
        smp(0, 0, 950, 2'b10, "R6 qualify 2");
        smp(0, 0, 950, 2'b00, "R5 R6 symmetrical window expiry");
        // R7: refault restarts the full unsymmetrical window
        smp(-800, -800, 300, 2'b01, "R2 negative trip");
        smp(0, 0, 1000, 2'b10, "R6 enter asym window");
        fault_sym = 1'b1;
        smp(0, 0, 1000, 2'b10, "R7 asym 1");
        smp(0, 0, 1000, 2'b10, "R7 asym 2");
        smp(700, -800, 1000, 2'b01, "R7 refault back to limit");
        fault_sym = 1'b0;
        smp(0, 0, 1000, 2'b10, "R7 reenter qualify");
        for (int i = 0; i < 4; i++) smp(0, 0, 1000, 2'b10, "R7 full window restarted");
        smp(0, 0, 1000, 2'b00, "R7 asym window expiry");
        // R8: dip during qualify
        smp(2000, 0, 100, 2'b01, "R8 trip");
        smp(0, 0, 1000, 2'b10, "R8 enter qualify");
        smp(0, 0, 899, 2'b01, "R8 dip returns to limit");
        // R5: zero window counts as one
        win_sym   = '0;
        fault_sym = 1'b1;
        smp(0, 0, 1000, 2'b10, "R5 enter zero window");
        smp(0, 0, 1000, 2'b00, "R5 zero window as one");
        // R2: full-scale corner
        trip_sq = MW'(33'h7FFF_FFFF);
        smp(-32768, -32768, 1000, 2'b01, "R2 full scale trip");
        // R10: reset from limit
        do_reset();
        smp(0, 0, 1000, 2'b00, "R10 after reset compensate");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule